// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller

This block is a small data cache placed between a processor load/store port and a slower memory port. Lines are 8 bytes (two 32-bit words). Each set holds two lines, and every line carries its own tag and valid bit. The number of sets is a parameter, with 512 sets by default, which gives 8 KB of data. Both ways of the selected set are looked up in the same cycle, and a read that hits returns its word in that cycle.

On a read miss the processor is held. The block asks memory for the whole line, which arrives as two words. It installs the line in one of the two ways and then completes the read as an ordinary hit. Writes always go through to memory by way of a single-entry buffer. A write that hits also updates the cached line, and a write that misses leaves the cache untouched. The processor is held only when a write finds the buffer occupied and memory not accepting it. A read miss also waits, because it does not fetch until the buffer is empty.

Top module: `wtCache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. The write buffer is empty (`memWrValid` low), `cpuStall` is low while no request is present, and `memRdReq` is low.
- R2: A read whose line is resident completes in the cycle it is presented: `cpuStall` is low and `cpuRdata` holds the current value of the addressed word.
- R3: Address fields: bits [2:0] locate the byte within the 8-byte line, and bit 2 picks the word (0 = lower word, first beat). The next INDEX_W bits pick the set, and the remaining upper bits form the tag. A read of the other word of a resident line hits.
- R4: On a read miss `cpuStall` is high and `memRdReq` is held with the line-aligned address (`memRdAddr[2:0]` = 0) until the second of two `memRdValid` beats (lower word first). The word is returned in the cycle after the second beat. With memory taking 6 cycles from request to last beat, a miss occupies 9 cycles including the completing one.
- R5: Two lines with the same set index and different tags can be resident together, and each one then hits.
- R6: A refill goes into an invalid way if the set has one. Otherwise the way comes from a pseudo-random bit that advances on every refill. Only that way is replaced, so the other resident line still hits.
- R7: An address never matches in both ways at once.
- R8: A write that hits changes only the bytes of the addressed word whose `cpuBe` bit is set (bit i covers data bits 8i+7:8i). Later reads return the merged word.
- R9: A write that misses leaves the cache unchanged, so a later read of that address misses and returns the written value from memory.
- R10: Every accepted write appears on the memory write port with its address, data and byte enables, in acceptance order, and is held stable until `memWrReady`. A write is accepted with no stall when the buffer is empty or draining in that cycle.
- R11: While the buffer is full and `memWrReady` is low, a presented write keeps `cpuStall` high.
- R12: A read-miss refill is not requested while the write buffer holds an entry, so the refill returns any value written just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request present, held until not stalled |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address |
| cpuBe | input | DATA_W/8 | Byte enables for writes |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid when a read is not stalled |
| cpuStall | output | 1 | Holds the processor |
| memRdReq | output | 1 | Line refill request |
| memRdAddr | output | ADDR_W | Line-aligned refill address |
| memRdValid | input | 1 | Refill beat valid |
| memRdData | input | DATA_W | Refill beat data |
| memWrValid | output | 1 | Buffered write present |
| memWrReady | input | 1 | Memory accepts the buffered write |
| memWrAddr | output | ADDR_W | Buffered write address |
| memWrData | output | DATA_W | Buffered write data |
| memWrBe | output | DATA_W/8 | Buffered write byte enables |

## Verification
The bench builds the block with INDEX_W = 4, so 16 sets, and leaves ADDR_W and DATA_W at 32. With only 16 sets, addresses 128 bytes apart share a set, so three-line conflicts and evictions happen within a few kilobytes of bench memory. The eviction scenario repeats in fifteen different sets, so both outcomes of the random way choice appear. Holding `memWrReady` low from the bench creates the buffer-full stall and the read-miss-behind-write case, and exact stall lengths are counted for each.

// File: rtl/wtcPkg.sv
package wtcPkg;
  localparam int WAYS        = 2;
  localparam int WORD_BYTES  = 4;
  localparam int LINE_WORDS  = 2;
  localparam int LFSR_W      = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [0:0] {ST_IDLE, ST_FILL} ctlState_t;

  typedef struct packed {
    logic wrHit;     // update the matching line with the write
    logic bufLoad;   // capture the accepted write in the buffer
    logic beatLoad;  // hold the first refill beat
    logic install;   // write the refilled line into the victim way
    logic victim;    // way chosen for the refill
  } ctlStrobe_t;
endpackage

// File: rtl/wtcDatapath.sv
module wtcDatapath
  import wtcPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 9,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W/8-1:0]   cpuBe,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [DATA_W-1:0]     memRdData,
  input  logic                  memWrReady,
  input  ctlStrobe_t            strobe,
  output logic [WAYS-1:0]       hitVec,
  output logic [WAYS-1:0]       setValid,
  output logic [DATA_W-1:0]     rdWord,
  output logic                  bufValid,
  output logic [ADDR_W-1:0]     memWrAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic [DATA_W/8-1:0]   memWrBe
);
  localparam int BE_W       = DATA_W / 8;
  localparam int WORD_OFF_W = $clog2(WORD_BYTES);
  localparam int OFFSET_W   = $clog2(WORD_BYTES * LINE_WORDS);
  localparam int SETS       = 1 << INDEX_W;
  localparam int TAG_W      = ADDR_W - INDEX_W - OFFSET_W;
  localparam int LINE_W     = DATA_W * LINE_WORDS;

  logic [INDEX_W-1:0] setIdx;
  logic [TAG_W-1:0]   reqTag;
  logic               wordSel;
  logic [DATA_W-1:0]  fillLow;
  logic [LINE_W-1:0]  lineOut [WAYS];
  logic [LINE_W-1:0]  lineMerged [WAYS];
  logic [LINE_W-1:0]  hitLine;

  assign setIdx  = cpuAddr[OFFSET_W +: INDEX_W];
  assign reqTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wordSel = cpuAddr[WORD_OFF_W];

  function automatic logic [LINE_W-1:0] mergeLine(
    input logic [LINE_W-1:0] oldLine,
    input logic              sel,
    input logic [BE_W-1:0]   be,
    input logic [DATA_W-1:0] wd
  );
    logic [LINE_W-1:0] res;
    res = oldLine;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) res[int'(sel) * DATA_W + b * 8 +: 8] = wd[b * 8 +: 8];
    end
    return res;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [LINE_W-1:0] dataMem [SETS];
    logic [SETS-1:0]   validBits;
    logic              isVictim;

    assign isVictim      = (int'(strobe.victim) == w);
    assign setValid[w]   = validBits[setIdx];
    assign hitVec[w]     = validBits[setIdx] && (tagMem[setIdx] == reqTag);
    assign lineOut[w]    = dataMem[setIdx];
    assign lineMerged[w] = mergeLine(dataMem[setIdx], wordSel, cpuBe, cpuWdata);

    always_ff @(posedge clk) begin
      if (rst) begin
        validBits <= '0;
      end else if (strobe.install && isVictim) begin
        validBits[setIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.install && isVictim) begin
        tagMem[setIdx]  <= reqTag;
        dataMem[setIdx] <= {memRdData, fillLow};
      end else if (strobe.wrHit && hitVec[w]) begin
        dataMem[setIdx] <= lineMerged[w];
      end
    end
  end

  always_comb begin
    hitLine = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitLine = lineOut[w];
    end
    rdWord = wordSel ? hitLine[DATA_W +: DATA_W] : hitLine[0 +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.beatLoad) fillLow <= memRdData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufValid <= 1'b0;
    end else if (strobe.bufLoad) begin
      bufValid <= 1'b1;
    end else if (bufValid && memWrReady) begin
      bufValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.bufLoad) begin
      memWrAddr <= cpuAddr;
      memWrData <= cpuWdata;
      memWrBe   <= cpuBe;
    end
  end
endmodule

// File: rtl/wtcControl.sv
module wtcControl
  import wtcPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cpuReq,
  input  logic            cpuWe,
  input  logic [WAYS-1:0] hitVec,
  input  logic [WAYS-1:0] setValid,
  input  logic            bufValid,
  input  logic            memWrReady,
  input  logic            memRdValid,
  output logic            cpuStall,
  output logic            memRdReq,
  output ctlStrobe_t      strobe
);
  ctlState_t         state;
  logic              beatSeen;
  logic [LFSR_W-1:0] lfsr;
  logic              anyHit;
  logic              rdStall;
  logic              wrStall;
  logic              wrAccept;

  assign anyHit = |hitVec;

  always_comb begin
    rdStall  = cpuReq && !cpuWe && !(state == ST_IDLE && anyHit);
    wrStall  = cpuReq && cpuWe && ((state != ST_IDLE) || (bufValid && !memWrReady));
    cpuStall = rdStall || wrStall;
    wrAccept = cpuReq && cpuWe && !wrStall;
    memRdReq = (state == ST_FILL) && !bufValid;

    strobe.wrHit    = wrAccept && anyHit;
    strobe.bufLoad  = wrAccept;
    strobe.beatLoad = (state == ST_FILL) && memRdValid && !beatSeen;
    strobe.install  = (state == ST_FILL) && memRdValid && beatSeen;
    if (!setValid[0])      strobe.victim = 1'b0;
    else if (!setValid[1]) strobe.victim = 1'b1;
    else                   strobe.victim = lfsr[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      beatSeen <= 1'b0;
      lfsr     <= LFSR_SEED;
    end else begin
      case (state)
        ST_IDLE: if (cpuReq && !cpuWe && !anyHit) state <= ST_FILL;
        ST_FILL: if (strobe.install) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (strobe.beatLoad)     beatSeen <= 1'b1;
      else if (strobe.install) beatSeen <= 1'b0;
      if (strobe.install)
        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
    end
  end
endmodule

// File: rtl/wtCache.sv
module wtCache
  import wtcPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 9,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpuReq,
  input  logic                cpuWe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W/8-1:0] cpuBe,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                cpuStall,
  output logic                memRdReq,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic                memRdValid,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memWrValid,
  input  logic                memWrReady,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrBe
);
  localparam int OFFSET_W = $clog2(WORD_BYTES * LINE_WORDS);

  ctlStrobe_t      strobe;
  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] setValid;
  logic            bufValid;

  assign memWrValid = bufValid;
  assign memRdAddr  = {cpuAddr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};

  wtcDatapath #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) dpInst (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuBe(cpuBe), .cpuWdata(cpuWdata),
    .memRdData(memRdData), .memWrReady(memWrReady), .strobe(strobe),
    .hitVec(hitVec), .setValid(setValid), .rdWord(cpuRdata), .bufValid(bufValid),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrBe(memWrBe)
  );

  wtcControl ctlInst (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .hitVec(hitVec),
    .setValid(setValid), .bufValid(bufValid), .memWrReady(memWrReady),
    .memRdValid(memRdValid), .cpuStall(cpuStall), .memRdReq(memRdReq), .strobe(strobe)
  );
endmodule

// File: rtl/wtcChecker.sv
module wtcChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuStall,
  input logic [1:0]        hitVec,
  input logic              memRdReq,
  input logic [2:0]        rdAddrLow,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData
);
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec)); // R7
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && !cpuWe && (|hitVec)) |-> !cpuStall); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && cpuWe && memWrValid && !memWrReady) |-> cpuStall); // R11
  AST_REFILL_BEHIND_WRITE: assert property (@(posedge clk) disable iff (rst)
    memRdReq |-> !memWrValid); // R12
  AST_REFILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    memRdReq |-> (rdAddrLow == 3'b000)); // R4
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData))); // R10
endmodule

bind wtCache wtcChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkInst (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuStall(cpuStall),
  .hitVec(hitVec), .memRdReq(memRdReq), .rdAddrLow(memRdAddr[2:0]),
  .memWrValid(memWrValid), .memWrReady(memWrReady),
  .memWrAddr(memWrAddr), .memWrData(memWrData)
);

// File: tb/tb_wtCache.sv
module tb_wtCache;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int LIMIT      = 150000;
  localparam int MISS_CYC   = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuRdata;
  logic        cpuStall, memRdReq, memWrValid;
  logic        memWrReady = 1'b1;
  logic [31:0] memRdAddr, memWrAddr, memWrData;
  logic [3:0]  memWrBe;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [31:0] lowerMem [MEM_WORDS];
  logic [31:0] archMem  [MEM_WORDS];
  logic [67:0] wrQueue  [$];
  logic        rdBusy = 1'b0;
  int          rdCnt = 0;
  logic [31:0] rdBase = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtCache #(.ADDR_W(32), .INDEX_W(4), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuBe(cpuBe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .memWrValid(memWrValid), .memWrReady(memWrReady),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrBe(memWrBe)
  );

  function automatic logic [31:0] mergeWord(logic [31:0] old, logic [3:0] be, logic [31:0] wd);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Lower-level memory: refill with 6 cycles from request to last beat, write drain.
  always @(posedge clk) begin
    if (rst) begin
      rdBusy <= 1'b0; memRdValid <= 1'b0;
    end else if (!rdBusy) begin
      memRdValid <= 1'b0;
      if (memRdReq) begin rdBusy <= 1'b1; rdCnt <= 0; rdBase <= memRdAddr; end
    end else begin
      rdCnt <= rdCnt + 1;
      if (rdCnt == 3) begin memRdValid <= 1'b1; memRdData <= lowerMem[{rdBase[13:3], 1'b0}]; end
      else if (rdCnt == 4) memRdData <= lowerMem[{rdBase[13:3], 1'b1}];
      else if (rdCnt == 5) begin memRdValid <= 1'b0; rdBusy <= 1'b0; end
    end
    if (!rst && memWrValid && memWrReady)
      lowerMem[memWrAddr[13:2]] <= mergeWord(lowerMem[memWrAddr[13:2]], memWrBe, memWrData);
  end

  // Reference model compared every clock.
  always @(negedge clk) begin
    if (!rst) begin
      if (cpuReq && !cpuWe && !cpuStall)
        check("R2/R4 read data", cpuRdata, archMem[cpuAddr[13:2]]);
      if (cpuReq && cpuWe && !cpuStall) begin
        archMem[cpuAddr[13:2]] = mergeWord(archMem[cpuAddr[13:2]], cpuBe, cpuWdata);
        wrQueue.push_back({cpuAddr, cpuWdata, cpuBe});
      end
      if (memWrValid && memWrReady) begin
        if (wrQueue.size() == 0) check("R10 unexpected drain", 32'd1, 32'd0);
        else begin
          check("R10 drained address", memWrAddr, wrQueue[0][67:36]);
          check("R10 drained data", memWrData, wrQueue[0][35:4]);
          check("R10 drained enables", {28'd0, memWrBe}, {28'd0, wrQueue[0][3:0]});
          void'(wrQueue.pop_front());
        end
      end
      if (memRdReq && memWrValid) check("R12 refill behind write", 32'd1, 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= LIMIT) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      summary();
    end
  end

  task automatic cpuOp(input logic we, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output int cyc, output logic [31:0] rd);
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuBe = be; cpuWdata = wd;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (cpuStall);
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  int c, c2, hitFirst = 0, missFirst = 0;
  logic [31:0] rd, expv;

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      lowerMem[i] = (i * 32'h9E3779B9) ^ 32'h13572468;
      archMem[i]  = lowerMem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 stall after reset", {31'd0, cpuStall}, 32'd0);
    check("R1 buffer empty after reset", {31'd0, memWrValid}, 32'd0);
    check("R1 no refill after reset", {31'd0, memRdReq}, 32'd0);

    cpuOp(1'b0, 32'h100, 4'h0, 32'h0, c, rd);
    check("R1/R4 first read misses, cycles", c, MISS_CYC);
    cpuOp(1'b0, 32'h104, 4'h0, 32'h0, c, rd);
    check("R3 other word of line hits, cycles", c, 1);
    check("R3 upper word value", rd, archMem[32'h104 >> 2]);
    cpuOp(1'b0, 32'h100, 4'h0, 32'h0, c, rd);
    check("R2 repeat read hits, cycles", c, 1);

    expv = mergeWord(archMem[32'h104 >> 2], 4'b0110, 32'hAABBCCDD);
    cpuOp(1'b1, 32'h104, 4'b0110, 32'hAABBCCDD, c, rd);
    check("R8/R10 write hit no stall, cycles", c, 1);
    cpuOp(1'b0, 32'h104, 4'h0, 32'h0, c, rd);
    check("R8 read after partial write hits, cycles", c, 1);
    check("R8 merged bytes", rd, expv);

    cpuOp(1'b0, 32'h180, 4'h0, 32'h0, c, rd);
    check("R5 second tag same set misses, cycles", c, MISS_CYC);
    cpuOp(1'b0, 32'h100, 4'h0, 32'h0, c, rd);
    check("R5 first line still resident, cycles", c, 1);
    cpuOp(1'b0, 32'h180, 4'h0, 32'h0, c, rd);
    check("R5 second line resident, cycles", c, 1);

    cpuOp(1'b1, 32'h1004, 4'hF, 32'h5A5A0F0F, c, rd);
    check("R9 write miss no stall, cycles", c, 1);
    cpuOp(1'b0, 32'h1004, 4'h0, 32'h0, c, rd);
    check("R9 read after write miss misses, cycles", c, MISS_CYC);
    check("R9 value from memory", rd, 32'h5A5A0F0F);

    for (int s = 1; s < 16; s++) begin
      cpuOp(1'b0, 32'h800 + s * 8, 4'h0, 32'h0, c, rd);
      cpuOp(1'b0, 32'h880 + s * 8, 4'h0, 32'h0, c, rd);
      cpuOp(1'b0, 32'h900 + s * 8, 4'h0, 32'h0, c, rd);
      cpuOp(1'b0, 32'h900 + s * 8, 4'h0, 32'h0, c, rd);
      check("R6 new line resident after eviction, cycles", c, 1);
      cpuOp(1'b0, 32'h800 + s * 8, 4'h0, 32'h0, c, rd);
      if (c == 1) begin
        hitFirst++;
        cpuOp(1'b0, 32'h880 + s * 8, 4'h0, 32'h0, c2, rd);
        check("R6 exactly one line evicted, cycles", c2, MISS_CYC);
      end else begin
        missFirst++;
        check("R6 evicted line refetch, cycles", c, MISS_CYC);
      end
    end
    check("R6 both victim ways chosen", {31'd0, (hitFirst > 0 && missFirst > 0)}, 32'd1);

    @(posedge clk); #1 memWrReady = 1'b0;
    cpuOp(1'b1, 32'h208, 4'b0001, 32'h000000EE, c, rd);
    check("R10 write into empty buffer, cycles", c, 1);
    fork
      cpuOp(1'b1, 32'h20C, 4'b1000, 32'h77000000, c, rd);
      begin repeat (5) @(posedge clk); #1 memWrReady = 1'b1; end
    join
    check("R11 write held while buffer full, cycles", c, 5);

    @(posedge clk); @(posedge clk); #1 memWrReady = 1'b0;
    cpuOp(1'b1, 32'h2000, 4'hF, 32'hC0FFEE11, c, rd);
    fork
      cpuOp(1'b0, 32'h2000, 4'h0, 32'h0, c, rd);
      begin repeat (10) @(posedge clk); #1 memWrReady = 1'b1; end
    join
    check("R12 refill waits for drain, cycles", c, 18);
    check("R12 refill returns pending write", rd, 32'hC0FFEE11);

    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 buffer empty after second reset", {31'd0, memWrValid}, 32'd0);
    cpuOp(1'b0, 32'h100, 4'h0, 32'h0, c, rd);
    check("R1 lines invalid after reset, cycles", c, MISS_CYC);
    repeat (4) @(posedge clk);
    check("R10 every write drained", wrQueue.size(), 0);
    summary();
  end
endmodule